// File: doc/BRIEF.md
# Block Memory Micro-Op Sequencer

This block turns one decoded block-transfer instruction into eight consecutive doubleword memory operations. A request arrives with two base operands (either two registers or a register and a signed immediate), an address-space identifier, the requester's privilege state, a load/store select, an address-narrowing select and the first floating-point register index. The block forms the effective address once and checks it. If the checks pass, it issues the eight transfers one after another over a valid/ready memory port.

Each transfer carries the address of its doubleword inside the 64-byte block, its position in the sequence, the register index it reads or writes, and commit markers. These markers tell the pipeline which operation opens the group, which one closes it, and which ones must hold their commit until the group ends. When a check fails, nothing is issued. The block reports a fault code for one cycle and returns to idle. A one-cycle done pulse marks the acceptance of the final transfer.

Top module: `blkmem_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, and `mem_valid`, `fault_valid` and `done` are 0.
- R2: The base address is `rs1 + rs2` when `req_use_imm` is 0, or `rs1` plus the 13-bit immediate sign-extended to 64 bits when it is 1. Transfer i (0 to 7) presents `mem_addr` = base + 8*i.
- R3: When `req_narrow` is 1, `mem_addr` carries only the low 32 bits of the sum and its upper 32 bits are zero. When it is 0, all 64 bits are used.
- R4: A request that passes the checks produces exactly eight accepted transfers, with `mem_uop_idx` running 0 to 7 in order.
- R5: Transfer i drives `rf_idx` = base register + i, modulo 64. `rf_wr_en` is 1 for loads and `rf_rd_en` is 1 for stores (`mem_is_store` = `req_is_store`). `mem_asi` repeats the request's identifier.
- R6: `mem_first` is 1 only on transfer 0. `mem_dly_commit` is 1 on transfers 0 to 6. `mem_last` is 1 only on transfer 7, where `mem_dly_commit` is 0.
- R7: If any of the low 6 bits of the base address is nonzero, the request faults with `fault_code` = 2'b10 (alignment).
- R8: If the identifier is below 0x80 and `req_priv` is 0, the request faults with `fault_code` = 2'b01 (privilege). When both conditions hold, the code is 2'b10.
- R9: The checks run once, in the cycle after acceptance. On a fault, `fault_valid` is 1 for exactly one cycle, in the second cycle after the accepting edge. In that cycle `req_ready` is 1, and no transfer is presented for that request.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, every `mem_*`, `rf_*` output stays unchanged.
- R11: `req_ready` is 0 from acceptance until the sequence ends. `done` is 1 for exactly one cycle, in the cycle after transfer 7 is accepted, and `req_ready` is 1 again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_is_store | input | 1 | 1 = block store, 0 = block load |
| req_use_imm | input | 1 | 1 = register + immediate form |
| req_rs1 | input | 64 | First base operand |
| req_rs2 | input | 64 | Second base operand (register form) |
| req_imm | input | 13 | Signed immediate (immediate form) |
| req_asi | input | 8 | Address-space identifier |
| req_priv | input | 1 | Requester privileged |
| req_narrow | input | 1 | Wrap addresses to 32 bits |
| req_freg | input | 6 | First floating-point register index |
| mem_valid | output | 1 | Transfer presented |
| mem_ready | input | 1 | Transfer accepted |
| mem_addr | output | 64 | Doubleword address |
| mem_is_store | output | 1 | Transfer direction |
| mem_asi | output | 8 | Identifier of the transfer |
| mem_uop_idx | output | 3 | Position in sequence |
| mem_first | output | 1 | Opens the group |
| mem_last | output | 1 | Closes the group |
| mem_dly_commit | output | 1 | Commit held until group end |
| rf_idx | output | 6 | Register index for this transfer |
| rf_wr_en | output | 1 | Register written (load) |
| rf_rd_en | output | 1 | Register read (store) |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 2 | 01 privilege, 10 alignment |
| done | output | 1 | Sequence complete pulse |

## Verification
The alignment check and the privilege check are evaluated in the same cycle, and only the first must surface when both fail. The bench provokes this with an unprivileged request that uses an identifier below 0x80 and a base address offset by a few bytes. It expects code 2'b10 and no transfer. The bench also sets up each check failing alone, and an identifier of exactly 0x80 that must pass. A second overlap is a memory stall on the final transfer. The bench judges it by the done pulse appearing only one cycle after the delayed acceptance.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CHECK = 2'd1,
    SEQ_ISSUE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PRIV  = 2'b01,
    FLT_ALIGN = 2'b10
  } fault_code_e;

  typedef struct packed {
    logic first;
    logic last;
    logic dly_commit;
  } uop_marks_t;

endpackage

// File: rtl/blkmem_ea_gen.sv
module blkmem_ea_gen #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 13
) (
  input  logic [XLEN-1:0]  rs1,
  input  logic [XLEN-1:0]  rs2,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  output logic [XLEN-1:0]  base_ea
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] second_op;

  always_comb begin
    imm_sext  = {{EXT_W{imm[IMM_W-1]}}, imm};
    second_op = use_imm ? imm_sext : rs2;
    base_ea   = rs1 + second_op;
  end

endmodule

// File: rtl/blkmem_fault_chk.sv
module blkmem_fault_chk
  import blkmem_pkg::*;
#(
  parameter int ASI_W          = 8,
  parameter int ALIGN_BITS     = 6,
  parameter int PRIV_ASI_BOUND = 128
) (
  input  logic [ALIGN_BITS-1:0] ea_low,
  input  logic [ASI_W-1:0]      asi,
  input  logic                  priv,
  output fault_code_e           code
);

  localparam logic [ASI_W-1:0] BOUND = ASI_W'(PRIV_ASI_BOUND);

  logic misaligned;
  logic priv_viol;

  always_comb begin
    misaligned = |ea_low;
    priv_viol  = (asi < BOUND) && !priv;
    // the alignment fault is resolved last, so it wins
    code = FLT_NONE;
    if (priv_viol)  code = FLT_PRIV;
    if (misaligned) code = FLT_ALIGN;
  end

endmodule

// File: rtl/blkmem_addr_unit.sv
module blkmem_addr_unit #(
  parameter int XLEN       = 64,
  parameter int NARROW_W   = 32,
  parameter int STEP_BYTES = 8,
  parameter int IDX_W      = 3
) (
  input  logic [XLEN-1:0]  base_ea,
  input  logic [IDX_W-1:0] idx,
  input  logic             narrow,
  output logic [XLEN-1:0]  addr
);

  localparam int STEP_SHIFT = $clog2(STEP_BYTES);

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] full_addr;

  always_comb begin
    offset    = XLEN'(idx) << STEP_SHIFT;
    full_addr = base_ea + offset;
  end

  generate
    if (NARROW_W < XLEN) begin : g_wrap
      always_comb begin
        addr = narrow ? {{(XLEN-NARROW_W){1'b0}}, full_addr[NARROW_W-1:0]} : full_addr;
      end
    end else begin : g_nowrap
      logic unused_narrow;
      always_comb begin
        unused_narrow = narrow;
        addr          = full_addr;
      end
    end
  endgenerate

endmodule

// File: rtl/blkmem_seq_ctrl.sv
module blkmem_seq_ctrl
  import blkmem_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int ASI_W    = 8,
  parameter int FREG_W   = 6,
  parameter int NUM_UOPS = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [XLEN-1:0]   in_ea,
  input  logic [ASI_W-1:0]  in_asi,
  input  logic              in_priv,
  input  logic              in_narrow,
  input  logic              in_store,
  input  logic [FREG_W-1:0] in_freg,
  input  fault_code_e       chk_code,
  input  logic              mem_ready,
  output logic              req_ready,
  output logic              mem_valid,
  output logic [IDX_W-1:0]  uop_idx,
  output logic [XLEN-1:0]   ea_q,
  output logic [ASI_W-1:0]  asi_q,
  output logic              priv_q,
  output logic              narrow_q,
  output logic              store_q,
  output logic [FREG_W-1:0] freg_q,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UOPS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             flt_v_q, flt_v_d;
  fault_code_e      flt_c_q, flt_c_d;
  logic             done_q, done_d;
  logic             cap_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    flt_v_d = 1'b0;
    flt_c_d = FLT_NONE;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = SEQ_CHECK;
        end
      end
      SEQ_CHECK: begin
        idx_d = '0;
        if (chk_code != FLT_NONE) begin
          flt_v_d = 1'b1;
          flt_c_d = chk_code;
          state_d = SEQ_IDLE;
        end else begin
          state_d = SEQ_ISSUE;
        end
      end
      SEQ_ISSUE: begin
        if (mem_ready) begin
          if (idx_q == LAST_IDX) begin
            done_d  = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      flt_v_q <= 1'b0;
      flt_c_q <= FLT_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      flt_v_q <= flt_v_d;
      flt_c_q <= flt_c_d;
      done_q  <= done_d;
    end
  end

  // request fields: enable-only capture, no reset needed
  always_ff @(posedge clk) begin
    if (cap_en) begin
      ea_q     <= in_ea;
      asi_q    <= in_asi;
      priv_q   <= in_priv;
      narrow_q <= in_narrow;
      store_q  <= in_store;
      freg_q   <= in_freg;
    end
  end

  always_comb begin
    req_ready   = (state_q == SEQ_IDLE);
    mem_valid   = (state_q == SEQ_ISSUE);
    uop_idx     = idx_q;
    fault_valid = flt_v_q;
    fault_code  = flt_c_q;
    done        = done_q;
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(uop_idx))); // R10
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid); // R9
  AST_FAULT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (!mem_valid && req_ready)); // R9
  AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_valid && mem_ready && (uop_idx == LAST_IDX)) && req_ready)); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11

endmodule

// File: rtl/blkmem_sequencer.sv
module blkmem_sequencer
  import blkmem_pkg::*;
#(
  parameter int XLEN           = 64,
  parameter int IMM_W          = 13,
  parameter int ASI_W          = 8,
  parameter int FREG_W         = 6,
  parameter int NUM_UOPS       = 8,
  parameter int STEP_BYTES     = 8,
  parameter int ALIGN_BITS     = 6,
  parameter int NARROW_W       = 32,
  parameter int PRIV_ASI_BOUND = 128,
  localparam int IDX_W         = $clog2(NUM_UOPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_store,
  input  logic              req_use_imm,
  input  logic [XLEN-1:0]   req_rs1,
  input  logic [XLEN-1:0]   req_rs2,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [ASI_W-1:0]  req_asi,
  input  logic              req_priv,
  input  logic              req_narrow,
  input  logic [FREG_W-1:0] req_freg,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_is_store,
  output logic [ASI_W-1:0]  mem_asi,
  output logic [IDX_W-1:0]  mem_uop_idx,
  output logic              mem_first,
  output logic              mem_last,
  output logic              mem_dly_commit,
  output logic [FREG_W-1:0] rf_idx,
  output logic              rf_wr_en,
  output logic              rf_rd_en,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UOPS - 1);

  logic [XLEN-1:0]   base_ea;
  logic [XLEN-1:0]   ea_q;
  logic [ASI_W-1:0]  asi_q;
  logic              priv_q, narrow_q, store_q;
  logic [FREG_W-1:0] freg_q;
  logic [IDX_W-1:0]  uop_idx;
  fault_code_e       chk_code;
  uop_marks_t        marks;

  blkmem_ea_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ea (
    .rs1     (req_rs1),
    .rs2     (req_rs2),
    .imm     (req_imm),
    .use_imm (req_use_imm),
    .base_ea (base_ea)
  );

  blkmem_seq_ctrl #(
    .XLEN(XLEN), .ASI_W(ASI_W), .FREG_W(FREG_W),
    .NUM_UOPS(NUM_UOPS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .in_ea       (base_ea),
    .in_asi      (req_asi),
    .in_priv     (req_priv),
    .in_narrow   (req_narrow),
    .in_store    (req_is_store),
    .in_freg     (req_freg),
    .chk_code    (chk_code),
    .mem_ready   (mem_ready),
    .req_ready   (req_ready),
    .mem_valid   (mem_valid),
    .uop_idx     (uop_idx),
    .ea_q        (ea_q),
    .asi_q       (asi_q),
    .priv_q      (priv_q),
    .narrow_q    (narrow_q),
    .store_q     (store_q),
    .freg_q      (freg_q),
    .fault_valid (fault_valid),
    .fault_code  (fault_code),
    .done        (done)
  );

  blkmem_fault_chk #(
    .ASI_W(ASI_W), .ALIGN_BITS(ALIGN_BITS), .PRIV_ASI_BOUND(PRIV_ASI_BOUND)
  ) u_chk (
    .ea_low (ea_q[ALIGN_BITS-1:0]),
    .asi    (asi_q),
    .priv   (priv_q),
    .code   (chk_code)
  );

  blkmem_addr_unit #(
    .XLEN(XLEN), .NARROW_W(NARROW_W), .STEP_BYTES(STEP_BYTES), .IDX_W(IDX_W)
  ) u_addr (
    .base_ea (ea_q),
    .idx     (uop_idx),
    .narrow  (narrow_q),
    .addr    (mem_addr)
  );

  always_comb begin
    marks.first      = (uop_idx == '0);
    marks.last       = (uop_idx == LAST_IDX);
    marks.dly_commit = !marks.last;
    mem_first        = marks.first;
    mem_last         = marks.last;
    mem_dly_commit   = marks.dly_commit;
    mem_uop_idx      = uop_idx;
    mem_is_store     = store_q;
    mem_asi          = asi_q;
    rf_idx           = freg_q + FREG_W'(uop_idx);
    rf_wr_en         = mem_valid && !store_q;
    rf_rd_en         = mem_valid && store_q;
  end

  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_last) |=>
      (mem_valid && (mem_addr == $past(mem_addr) + XLEN'(STEP_BYTES)))); // R2
  AST_REG_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_last) |=>
      (rf_idx == $past(rf_idx) + 1'b1)); // R5
  AST_OPENS_WITH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> (mem_first && mem_dly_commit)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(rf_idx))); // R10

endmodule

// File: tb/blkmem_sequencer_test.sv
module blkmem_sequencer_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_is_store, req_use_imm;
  logic [63:0] req_rs1, req_rs2;
  logic [12:0] req_imm;
  logic [7:0]  req_asi;
  logic        req_priv, req_narrow;
  logic [5:0]  req_freg;
  logic        mem_valid, mem_ready, mem_is_store;
  logic [63:0] mem_addr;
  logic [7:0]  mem_asi;
  logic [2:0]  mem_uop_idx;
  logic        mem_first, mem_last, mem_dly_commit;
  logic [5:0]  rf_idx;
  logic        rf_wr_en, rf_rd_en;
  logic        fault_valid;
  logic [1:0]  fault_code;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  blkmem_sequencer uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_store(req_is_store), .req_use_imm(req_use_imm),
    .req_rs1(req_rs1), .req_rs2(req_rs2), .req_imm(req_imm),
    .req_asi(req_asi), .req_priv(req_priv), .req_narrow(req_narrow),
    .req_freg(req_freg),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_is_store(mem_is_store), .mem_asi(mem_asi), .mem_uop_idx(mem_uop_idx),
    .mem_first(mem_first), .mem_last(mem_last), .mem_dly_commit(mem_dly_commit),
    .rf_idx(rf_idx), .rf_wr_en(rf_wr_en), .rf_rd_en(rf_rd_en),
    .fault_valid(fault_valid), .fault_code(fault_code), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] exp_ea(input logic [63:0] a, input logic [63:0] b,
                                         input logic [12:0] im, input bit use_im);
    logic [63:0] sx;
    sx = {{51{im[12]}}, im};
    return use_im ? a + sx : a + b;
  endfunction

  function automatic logic [63:0] exp_addr(input logic [63:0] ea, input int i, input bit nar);
    logic [63:0] s;
    s = ea + 64'(8 * i);
    return nar ? {32'h0, s[31:0]} : s;
  endfunction

  function automatic logic [1:0] exp_fault(input logic [63:0] ea, input logic [7:0] asi,
                                           input bit pr);
    if (ea[5:0] != 6'd0) return 2'b10;
    if (asi < 8'h80 && !pr) return 2'b01;
    return 2'b00;
  endfunction

  task automatic run_txn(input logic [63:0] a, input logic [63:0] b, input logic [12:0] im,
                         input bit use_im, input logic [7:0] asi, input bit pr, input bit nar,
                         input bit st, input logic [5:0] fr, input int stall_pct);
    logic [63:0] ea;
    logic [1:0]  fc;
    string       atag;
    ea   = exp_ea(a, b, im, use_im);
    fc   = exp_fault(ea, asi, pr);
    atag = nar ? "R3 addr" : "R2 addr";
    @(negedge clk);
    chk("R11 ready idle", 64'(req_ready), 64'd1);
    req_valid = 1; req_rs1 = a; req_rs2 = b; req_imm = im; req_use_imm = use_im;
    req_asi = asi; req_priv = pr; req_narrow = nar; req_is_store = st; req_freg = fr;
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    chk("R11 busy not ready", 64'(req_ready), 64'd0);
    chk("R9 check cycle no issue", 64'(mem_valid), 64'd0);
    chk("R9 check cycle no fault", 64'(fault_valid), 64'd0);
    @(negedge clk);
    if (fc != 2'b00) begin
      chk("R9 fault pulse", 64'(fault_valid), 64'd1);
      chk(fc == 2'b10 ? "R7 fault code" : "R8 fault code", 64'(fault_code), 64'(fc));
      chk("R9 no issue on fault", 64'(mem_valid), 64'd0);
      chk("R9 idle on fault", 64'(req_ready), 64'd1);
      @(negedge clk);
      chk("R9 fault one cycle", 64'(fault_valid), 64'd0);
      chk("R9 still no issue", 64'(mem_valid), 64'd0);
      return;
    end
    for (int i = 0; i < 8; i++) begin
      bit stall;
      stall = ($urandom % 100) < stall_pct;
      chk("R4 valid", 64'(mem_valid), 64'd1);
      chk("R4 index", 64'(mem_uop_idx), 64'(i));
      chk(atag, mem_addr, exp_addr(ea, i, nar));
      chk("R5 reg index", 64'(rf_idx), 64'(6'(fr + 6'(i))));
      chk("R5 write en", 64'(rf_wr_en), 64'(!st));
      chk("R5 read en", 64'(rf_rd_en), 64'(st));
      chk("R5 direction", 64'(mem_is_store), 64'(st));
      chk("R5 asi", 64'(mem_asi), 64'(asi));
      chk("R6 first", 64'(mem_first), 64'(i == 0));
      chk("R6 last", 64'(mem_last), 64'(i == 7));
      chk("R6 delayed commit", 64'(mem_dly_commit), 64'(i != 7));
      chk("R9 no fault on pass", 64'(fault_valid), 64'd0);
      if (stall) begin
        mem_ready = 0;
        @(negedge clk);
        chk("R10 held valid", 64'(mem_valid), 64'd1);
        chk("R10 held index", 64'(mem_uop_idx), 64'(i));
        chk("R10 held addr", mem_addr, exp_addr(ea, i, nar));
        chk("R10 held reg", 64'(rf_idx), 64'(6'(fr + 6'(i))));
        chk("R11 no early done", 64'(done), 64'd0);
      end
      mem_ready = 1;
      @(negedge clk);
    end
    mem_ready = 0;
    chk("R11 done pulse", 64'(done), 64'd1);
    chk("R4 exactly eight", 64'(mem_valid), 64'd0);
    chk("R11 ready after done", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk("R11 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234567));
    rst_n = 0; req_valid = 0; req_is_store = 0; req_use_imm = 0;
    req_rs1 = 0; req_rs2 = 0; req_imm = 0; req_asi = 0; req_priv = 0;
    req_narrow = 0; req_freg = 0; mem_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset valid", 64'(mem_valid), 64'd0);
    chk("R1 reset fault", 64'(fault_valid), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 post reset ready", 64'(req_ready), 64'd1);
    chk("R1 post reset valid", 64'(mem_valid), 64'd0);

    // directed corners
    run_txn(64'h0000_0000_0001_0000, 64'h40, 13'h0, 0, 8'h80, 1, 0, 0, 6'd0, 0);      // R2 reg form
    run_txn(64'h1000, 64'h0, 13'h1FC0, 1, 8'h88, 0, 0, 1, 6'd8, 0);                   // R2 negative imm
    run_txn(64'hDEAD_BEEF_0000_0040, 64'h100, 13'h0, 0, 8'h90, 1, 1, 0, 6'd16, 0);   // R3 narrow
    run_txn(64'hDEAD_BEEF_0000_0040, 64'h100, 13'h0, 0, 8'h90, 1, 0, 0, 6'd16, 0);   // R3 wide
    run_txn(64'h2000, 64'h0, 13'h0, 0, 8'h91, 1, 0, 1, 6'd60, 0);                     // R5 wrap
    run_txn(64'h3000, 64'h0, 13'h0, 0, 8'h10, 0, 0, 0, 6'd0, 0);                      // R8 priv only
    run_txn(64'h3004, 64'h0, 13'h0, 0, 8'h10, 0, 0, 0, 6'd0, 0);                      // R8 both -> align
    run_txn(64'h3000, 64'h0, 13'h8, 1, 8'h04, 1, 0, 1, 6'd0, 0);                      // R7 align only
    run_txn(64'h4000, 64'h0, 13'h0, 0, 8'h80, 0, 0, 0, 6'd4, 0);                      // R8 boundary pass
    run_txn(64'h4000, 64'h0, 13'h0, 0, 8'h7F, 0, 0, 0, 6'd4, 0);                      // R8 boundary fault
    run_txn(64'h5000, 64'h40, 13'h0, 0, 8'hC0, 1, 0, 1, 6'd32, 100);                  // R10 stall all

    for (int t = 0; t < 60; t++) begin
      logic [63:0] a, b;
      logic [12:0] im;
      bit use_im;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      im = 13'($urandom);
      use_im = $urandom % 2;
      if (($urandom % 4) != 0) begin
        a[5:0] = 6'd0; b[5:0] = 6'd0; im[5:0] = 6'd0;
      end
      run_txn(a, b, im, use_im, 8'($urandom), $urandom % 2, $urandom % 2,
              $urandom % 2, 6'($urandom), 30);
    end
    finish_run();
  end

endmodule